// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a bank of interrupt request lines and a processor core. It drives two outputs. The fast output is for low-latency work. The normal output is for everything else. Software chooses which output each source uses, and it can enable or mask each source on its own.

Normal requests are ranked through a set of programmable vector slots. Each slot names one source and holds the handler address for it. Slot 0 ranks highest. An enabled normal source that no enabled slot claims falls into a shared default level, which ranks below every slot and returns a common default address. The handler at that address must then find out for itself which source fired.

Reading the vector port returns the handler address of the winning level and puts that level into service. While a level is in service, requests of equal or lower rank cannot raise the normal output. A request of higher rank can still raise it, so handlers nest. An end-of-service write releases the highest-ranked level in service.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset every source is masked, no source is fast-selected, every slot is disabled, the default address is 0 and nothing is in service. Both outputs are low and the vector port reads 0 whatever the request lines do.
- R2: `fiq_out` is high exactly when some source is asserted, enabled and fast-selected. A fast-selected source never raises `irq_out` and never affects the vector port.
- R3: When several enabled slots have asserted sources, the vector port returns the address of the lowest-numbered slot among them.
- R4: A slot takes part only while its enable bit is 1. It matches only the source whose number is in its 5-bit source field. A control write sets the source field from `wr_data[4:0]` and the enable bit from `wr_data[5]`.
- R5: An enabled, normal, asserted source that no enabled slot claims raises `irq_out` at the default level, and the vector port returns the default address. Any pending vectored slot outranks the default level.
- R6: A source whose enable bit is 0 has no effect on either output or on the vector port.
- R7: A read strobe while `irq_out` is high puts the winning level into service. After that, `irq_out` stays low for requests of that level or of lower rank.
- R8: While a level is in service, a pending request of higher rank raises `irq_out`. A read then puts that level into service as well, so levels nest.
- R9: An end-of-service write removes the highest-ranked level from service. Requests of lower rank that are still pending then raise `irq_out` again.
- R10: An end-of-service write while nothing is in service has no effect.
- R11: While `irq_out` is low the vector port returns the default address. A read strobe at that time puts nothing into service.
- R12: Write kinds on `wr_kind`:
  - 0 loads the fast-select mask from `wr_data`.
  - 1 loads the source-enable mask from `wr_data`.
  - 2 loads slot `wr_idx` control.
  - 3 loads slot `wr_idx` address.
  - 4 loads the default address.
  - 5 is end of service, and its data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | NSRC | Request lines, active high, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Selects which register the write targets (R12) |
| wr_idx | input | log2(NSLOT) | Slot number for slot writes |
| wr_data | input | AW | Write data |
| rd_en | input | 1 | Vector read strobe; marks the winning level in service |
| rd_data | output | AW | Current vector address |
| fiq_out | output | 1 | Fast interrupt request to the core |
| irq_out | output | 1 | Normal interrupt request to the core |

## Verification
The bench drives every source alone and then every pair of slotted sources. It checks rank order, the choice of output and the fallback to the default address. A priority encoder that scans in the wrong direction would return the higher slot's address in the pair sweep. A design that vectors fast sources would show a slot address on the port when only a fast-selected source is asserted.

The nesting script goes after the service record. It reads while nothing is pending, reads twice during one handler, and releases an inner level while the outer level still has a request pending. A design that pops the wrong end of the record would keep `irq_out` low after the inner release. A design that marks a level on an idle read would block a later default-level request. A design that lets the default level outrank a slot would return the default address during a nested slot request.

// File: rtl/iva_pkg.sv
package iva_pkg;

   // Register targets of the write port; the values are the wr_kind encoding.
   typedef enum logic [2:0] {
      WK_FAST_SEL  = 3'd0,
      WK_SRC_EN    = 3'd1,
      WK_SLOT_CTRL = 3'd2,
      WK_SLOT_ADDR = 3'd3,
      WK_DEFAULT   = 3'd4,
      WK_DONE      = 3'd5
   } wr_kind_e;

endpackage

// File: rtl/iva_first_set.sv
// Finds the lowest set bit of a request vector; returns N when none is set.
module iva_first_set #(
   parameter int N = 17
) (
   input  logic [N-1:0]             vec,
   output logic                     found,
   output logic [$clog2(N+1)-1:0]   idx
);
   localparam int IW = $clog2(N+1);

   always_comb begin
      idx = IW'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign found = |vec;
endmodule

// File: rtl/iva_svc_stack.sv
// Records which priority levels are in service; the top is the highest-ranked one.
module iva_svc_stack #(
   parameter int NLVL = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mark,
   input  logic [$clog2(NLVL+1)-1:0]   mark_lvl,
   input  logic                        done,
   output logic [NLVL-1:0]             svc_mask,
   output logic [$clog2(NLVL+1)-1:0]   top_lvl
);
   logic [NLVL-1:0] svc_nxt;
   logic            busy;

   iva_first_set #(.N(NLVL)) u_top (
      .vec   (svc_mask),
      .found (busy),
      .idx   (top_lvl)
   );

   always_comb begin
      svc_nxt = svc_mask;
      if (done && busy) svc_nxt[top_lvl] = 1'b0;
      if (mark && (mark_lvl < NLVL)) svc_nxt[mark_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_mask <= '0;
      else        svc_mask <= svc_nxt;
   end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
   import iva_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int NSLOT = 16,
   parameter int AW    = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSRC-1:0]            irq_src,
   input  logic                       wr_en,
   input  logic [2:0]                 wr_kind,
   input  logic [$clog2(NSLOT)-1:0]   wr_idx,
   input  logic [AW-1:0]              wr_data,
   input  logic                       rd_en,
   output logic [AW-1:0]              rd_data,
   output logic                       fiq_out,
   output logic                       irq_out
);
   localparam int SW   = $clog2(NSRC);
   localparam int SXW  = $clog2(NSLOT);
   localparam int NLVL = NSLOT + 1;
   localparam int LW   = $clog2(NLVL + 1);

   if (NSRC < 2 || (1 << SW) != NSRC) begin : g_bad_nsrc
      $error("NSRC must be a power of two of at least 2");
   end
   if (NSLOT < 2 || (1 << SXW) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two of at least 2");
   end
   if (AW < NSRC || AW < SW + 1) begin : g_bad_aw
      $error("AW must hold a full source mask and a slot control word");
   end

   logic [NSRC-1:0]           fast_sel, src_en, req_fast, req_norm, covered;
   logic [NSLOT-1:0]          slot_en, slot_hit;
   logic [NSLOT-1:0][SW-1:0]  slot_src;
   logic [NSLOT-1:0][AW-1:0]  slot_addr;
   logic [AW-1:0]             dflt_addr;
   logic [NLVL-1:0]           lvl_req, svc_mask;
   logic [LW-1:0]             win_lvl, top_lvl;
   logic                      win_any, mark, done;
   wr_kind_e                  kind;

   assign kind = wr_kind_e'(wr_kind);

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_sel  <= '0;
         src_en    <= '0;
         slot_en   <= '0;
         slot_src  <= '0;
         slot_addr <= '0;
         dflt_addr <= '0;
      end else if (wr_en) begin
         case (kind)
            WK_FAST_SEL:  fast_sel <= wr_data[NSRC-1:0];
            WK_SRC_EN:    src_en   <= wr_data[NSRC-1:0];
            WK_SLOT_CTRL: begin
               slot_en[wr_idx]  <= wr_data[SW];
               slot_src[wr_idx] <= wr_data[SW-1:0];
            end
            WK_SLOT_ADDR: slot_addr[wr_idx] <= wr_data;
            WK_DEFAULT:   dflt_addr <= wr_data;
            default:      ;
         endcase
      end
   end

   assign req_fast = irq_src & src_en & fast_sel;
   assign req_norm = irq_src & src_en & ~fast_sel;
   assign fiq_out  = |req_fast;

   // Per-slot source match
   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign slot_hit[k] = slot_en[k] & req_norm[slot_src[k]];
   end

   always_comb begin
      covered = '0;
      for (int k = 0; k < NSLOT; k++) begin
         if (slot_en[k]) covered[slot_src[k]] = 1'b1;
      end
   end

   // Level NSLOT is the shared default level, ranked below every slot.
   assign lvl_req = {|(req_norm & ~covered), slot_hit};

   iva_first_set #(.N(NLVL)) u_win (
      .vec   (lvl_req),
      .found (win_any),
      .idx   (win_lvl)
   );

   assign irq_out = win_any && (win_lvl < top_lvl);
   assign rd_data = (irq_out && (win_lvl < LW'(NSLOT)))
                    ? slot_addr[win_lvl[SXW-1:0]] : dflt_addr;
   assign mark    = rd_en && irq_out;
   assign done    = wr_en && (kind == WK_DONE);

   iva_svc_stack #(.NLVL(NLVL)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .mark     (mark),
      .mark_lvl (win_lvl),
      .done     (done),
      .svc_mask (svc_mask),
      .top_lvl  (top_lvl)
   );
endmodule

// File: rtl/iva_checks.sv
module iva_checks #(
   parameter int NSRC = 32,
   parameter int NLVL = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NSRC-1:0]  irq_src,
   input logic             wr_en,
   input logic [2:0]       wr_kind,
   input logic             rd_en,
   input logic             irq_out,
   input logic             fiq_out,
   input logic [NLVL-1:0]  svc_mask
);
   logic eos;
   assign eos = wr_en && (wr_kind == 3'd5);

   p_fiq_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_out |-> (|irq_src));

   p_irq_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|irq_src));

   p_top_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      svc_mask[0] |-> !irq_out);

   p_read_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && irq_out && !eos) |=> (svc_mask != '0));

   p_single_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(svc_mask) <= $countones($past(svc_mask)) + 1));

   p_release_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eos && (svc_mask != '0) && !rd_en)
      |=> ($countones(svc_mask) + 1 == $countones($past(svc_mask))));

   p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (eos && (svc_mask == '0) && !(rd_en && irq_out)) |=> (svc_mask == '0));
endmodule

bind irq_vector_arbiter iva_checks #(.NSRC(NSRC), .NLVL(NSLOT + 1)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_src  (irq_src),
   .wr_en    (wr_en),
   .wr_kind  (wr_kind),
   .rd_en    (rd_en),
   .irq_out  (irq_out),
   .fiq_out  (fiq_out),
   .svc_mask (svc_mask)
);

// File: tb/sim_irq_vector_arbiter.sv
module sim_irq_vector_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] DFLT = 32'hDEF0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_src = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_kind = '0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        fiq_out, irq_out;

   int nvec = 0;
   int nbad = 0;
   bit ended = 1'b0;

   logic [31:0] b_addr [16];
   logic [4:0]  b_src  [16];
   logic        b_en   [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .wr_en(wr_en),
      .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .fiq_out(fiq_out), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] k, input int idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_idx = idx[3:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic drive(input logic [31:0] v);
      @(negedge clk);
      irq_src = v;
      #1;
   endtask

   task automatic pulse_rd();
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
   endtask

   // Expected vector with nothing in service: lowest enabled matching slot, else default.
   function automatic logic [31:0] exp_vec(input logic [31:0] v);
      for (int k = 0; k < 16; k++) begin
         if (b_en[k] && v[b_src[k]]) return b_addr[k];
      end
      return DFLT;
   endfunction

   function automatic logic [31:0] bit1(input logic b);
      return {31'b0, b};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!ended) begin
         ended = 1'b1;
         nvec++; nbad++;
         $display("FAIL watchdog got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic [31:0] fmask, emask;
      fmask = 32'hAAAA_AAAA;
      emask = 32'h0FF0_F00F;
      for (int k = 0; k < 16; k++) begin
         b_src[k]  = 5'((3 * k + 5) % 32);
         b_addr[k] = 32'h4000_0000 + 32'(k) * 32'h100 + 32'(k);
         b_en[k]   = 1'b1;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive(32'hFFFF_FFFF);
      chk("R1 fiq after reset", bit1(fiq_out), 32'd0);
      chk("R1 irq after reset", bit1(irq_out), 32'd0);
      chk("R1 vector after reset", rd_data, 32'd0);
      drive(32'h0);

      // Sweep: output steering and masking, no slots configured.
      wr(3'd4, 0, DFLT);
      wr(3'd0, 0, fmask);
      wr(3'd1, 0, emask);
      for (int s = 0; s < 32; s++) begin
         drive(32'h1 << s);
         chk($sformatf("R2 fiq src %0d", s), bit1(fiq_out), bit1(fmask[s] & emask[s]));
         chk($sformatf("R6 irq src %0d", s), bit1(irq_out), bit1(~fmask[s] & emask[s]));
         chk($sformatf("R5 vector src %0d", s), rd_data, DFLT);
      end

      // Sweep: slot priority and matching.
      wr(3'd0, 0, 32'h0);
      wr(3'd1, 0, 32'hFFFF_FFFF);
      for (int k = 0; k < 16; k++) begin
         wr(3'd2, k, {26'b0, 1'b1, b_src[k]});
         wr(3'd3, k, b_addr[k]);
      end
      for (int s = 0; s < 32; s++) begin
         drive(32'h1 << s);
         chk($sformatf("R4 irq src %0d", s), bit1(irq_out), 32'd1);
         chk($sformatf("R4 vector src %0d", s), rd_data, exp_vec(32'h1 << s));
      end
      for (int a = 0; a < 16; a++) begin
         for (int b = a + 1; b < 16; b++) begin
            drive((32'h1 << b_src[a]) | (32'h1 << b_src[b]));
            chk($sformatf("R3 pair %0d/%0d", a, b), rd_data, b_addr[a]);
         end
      end
      drive((32'h1 << 1) | (32'h1 << b_src[15]));
      chk("R5 slot beats default", rd_data, b_addr[15]);

      wr(3'd2, 0, {27'b0, b_src[0]});
      b_en[0] = 1'b0;
      drive(32'h1 << b_src[0]);
      chk("R4 disabled slot", rd_data, DFLT);
      wr(3'd2, 0, {26'b0, 1'b1, b_src[0]});
      b_en[0] = 1'b1;
      chk("R4 re-enabled slot", rd_data, b_addr[0]);

      // Service nesting: slot1 = src 8, slot3 = src 14, slot5 = src 20, src 1 = default.
      drive(32'h1 << 14);
      chk("R7 pending slot3", rd_data, b_addr[3]);
      pulse_rd();
      chk("R7 irq after read", bit1(irq_out), 32'd0);
      chk("R11 vector idle", rd_data, DFLT);
      pulse_rd();
      drive((32'h1 << 14) | (32'h1 << 20));
      chk("R7 lower blocked", bit1(irq_out), 32'd0);
      drive((32'h1 << 14) | (32'h1 << 20) | (32'h1 << 8));
      chk("R8 nested irq", bit1(irq_out), 32'd1);
      chk("R8 nested vector", rd_data, b_addr[1]);
      pulse_rd();
      chk("R8 nested marked", bit1(irq_out), 32'd0);
      wr(3'd5, 0, 32'hFFFF_FFFF);
      chk("R9 inner released", bit1(irq_out), 32'd1);
      chk("R9 inner vector", rd_data, b_addr[1]);
      drive((32'h1 << 14) | (32'h1 << 20));
      chk("R9 outer still held", bit1(irq_out), 32'd0);
      wr(3'd5, 0, 32'h0);
      chk("R9 outer released", bit1(irq_out), 32'd1);
      chk("R9 outer vector", rd_data, b_addr[3]);

      drive(32'h0);
      wr(3'd5, 0, 32'h0);
      pulse_rd();
      drive(32'h1 << 20);
      chk("R10 idle release", bit1(irq_out), 32'd1);
      chk("R10 idle release vector", rd_data, b_addr[5]);

      drive(32'h1 << 1);
      chk("R11 default after idle read", bit1(irq_out), 32'd1);
      chk("R5 default vector", rd_data, DFLT);
      pulse_rd();
      chk("R7 default marked", bit1(irq_out), 32'd0);
      drive((32'h1 << 1) | (32'h1 << 20));
      chk("R8 slot over default", rd_data, b_addr[5]);
      drive((32'h1 << 1) | (32'h1 << 2));
      chk("R5 default blocked", bit1(irq_out), 32'd0);
      wr(3'd5, 0, 32'h0);
      chk("R9 default released", bit1(irq_out), 32'd1);
      chk("R9 default vector", rd_data, DFLT);

      // Fast sources bypass vectoring.
      drive(32'h0);
      wr(3'd0, 0, 32'h1 << 14);
      drive(32'h1 << 14);
      chk("R2 fast fiq", bit1(fiq_out), 32'd1);
      chk("R2 fast no irq", bit1(irq_out), 32'd0);
      chk("R2 fast no vector", rd_data, DFLT);
      drive((32'h1 << 14) | (32'h1 << 20));
      chk("R12 mask write slot5", rd_data, b_addr[5]);

      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule